// File: doc/BRIEF.md
# PCM Receive Time-Slot Extractor

This block pulls one channel's receive sample out of a serial time-division multiplexed PCM stream. The stream arrives as a bit clock, a frame-sync pulse and a serial data line. All three are synchronised into the block's own clock domain. Each falling edge of the bit clock becomes a one-cycle strobe, and the data and frame-sync levels are sampled at that strobe.

A rising frame sync marks bit position zero of a frame. A position counter then advances by one on every later bit. The channel's start position counts bits from the frame sync. Its upper bits are a time-slot number and its three low bits are a separate bit offset, so a sample can begin at any bit, not only on a slot boundary.

The block has two formats. In companded format it captures 8 bits. In linear format it captures 16 bits, which fill two adjacent slots. When the last bit has been shifted in, the block presents the word and raises a one-cycle valid pulse. A channel-active bit switches the whole capture path on or off.

Top module: `pcm_rx_slot_extract`

## Requirements
- R1: After reset, the time slot is 16 × CHAN_IDX, the bit offset is 0, the format is companded and the channel is inactive. `sample_valid` is 0 and `sample_data` is 0.
- R2: The first captured bit is the one at position slot × 8 + bit offset. Position 0 is the bit sampled together with the frame sync's rising level.
- R3: Data is sampled on falling bit-clock edges, one bit per edge, most significant bit first.
- R4: In companded format (`cfg_linear`=0), 8 bits are captured and placed in `sample_data[7:0]`, and `sample_data[15:8]` is 0.
- R5: In linear format (`cfg_linear`=1), 16 consecutive bits spanning two adjacent slots are captured into `sample_data[15:0]`.
- R6: `sample_valid` is high for exactly one clock cycle after the last bit of a sample is captured. `sample_data` changes only in that cycle and holds its value otherwise.
- R7: While `cfg_active` is 0, no sample is produced. Deactivating during a capture abandons the partial sample.
- R8: A frame sync that arrives during a capture abandons the partial sample and restarts the position count at 0.
- R9: Only a low-to-high change of the sampled frame sync starts a frame. A frame sync held high over several bits does not restart the count.
- R10: Before the first frame sync after reset, no sample is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_in | input | 1 | Serial bit clock (asynchronous) |
| fs_in | input | 1 | Frame sync (asynchronous) |
| din_in | input | 1 | Serial receive data (asynchronous) |
| cfg_wr_place | input | 1 | Write strobe for the slot and bit-offset fields |
| cfg_slot | input | SLOT_W | Time-slot number to write |
| cfg_bitoff | input | 3 | Bit offset to write |
| cfg_wr_mode | input | 1 | Write strobe for the format and active fields |
| cfg_linear | input | 1 | Format to write: 1 = 16-bit linear, 0 = 8-bit companded |
| cfg_active | input | 1 | Channel active bit to write |
| sample_data | output | 16 | Last captured sample |
| sample_valid | output | 1 | One-cycle pulse when a new sample is presented |

## Verification
The assertions check on every cycle that:
- the valid pulse is one cycle wide and the data holds between pulses;
- the upper byte is zero for companded samples;
- the bit counter stays inside the sample length;
- a rising frame sync zeroes the position, and a frame sync held high does not;
- an inactive channel never signals valid.

Only the bench scenarios can show the rest:
- that the captured bits come from the right position, for both slot and bit offset;
- that the bits arrive in MSB-first order;
- that a capture interrupted by a frame sync or by deactivation yields nothing;
- that the reset defaults place the sample at slot 16 × CHAN_IDX.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;
  localparam int SLOT_BITS = 8;
  localparam int WORD_BITS = 2 * SLOT_BITS;

  typedef enum logic {
    FMT_COMPANDED = 1'b0,
    FMT_LINEAR    = 1'b1
  } fmt_e;
endpackage

// File: rtl/pcm_rx_sync.sv
module pcm_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_raw,
  input  logic fs_raw,
  input  logic din_raw,
  output logic bit_strobe,
  output logic fs_s,
  output logic din_s
);
  // Per stage: bit 2 = bit clock, bit 1 = frame sync, bit 0 = data.
  logic [2:0] stage_q [STAGES];
  logic       bclk_last_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      logic [2:0] stage_d;
      if (g == 0) begin : g_first
        assign stage_d = {bclk_raw, fs_raw, din_raw};
      end else begin : g_next
        assign stage_d = stage_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= 3'b000;
        else        stage_q[g] <= stage_d;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bclk_last_q <= 1'b0;
    else        bclk_last_q <= stage_q[STAGES-1][2];
  end

  always_comb begin
    bit_strobe = bclk_last_q & ~stage_q[STAGES-1][2];
    fs_s       = stage_q[STAGES-1][1];
    din_s      = stage_q[STAGES-1][0];
  end

  // A falling edge can never produce strobes on two consecutive cycles.
  p_single_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bit_strobe |=> !bit_strobe);
endmodule

// File: rtl/pcm_rx_cfg.sv
module pcm_rx_cfg #(
  parameter int CHAN_IDX = 1,
  parameter int SLOT_W   = 7,
  localparam int POS_W   = SLOT_W + 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_place,
  input  logic [SLOT_W-1:0] slot_in,
  input  logic [2:0]       bitoff_in,
  input  logic             wr_mode,
  input  logic             linear_in,
  input  logic             active_in,
  output logic [POS_W-1:0] start_pos,
  output logic             linear,
  output logic             active
);
  localparam int DEF_SLOT = 16 * CHAN_IDX;
  localparam logic [SLOT_W-1:0] DEF_SLOT_V = SLOT_W'(DEF_SLOT);

  logic [POS_W-1:0] place_q, place_d;
  logic             lin_q, lin_d, act_q, act_d;

  always_comb begin
    place_d = place_q;
    lin_d   = lin_q;
    act_d   = act_q;
    if (wr_place) place_d = {slot_in, bitoff_in};
    if (wr_mode) begin
      lin_d = linear_in;
      act_d = active_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      place_q <= {DEF_SLOT_V, 3'b000};
      lin_q   <= 1'b0;
      act_q   <= 1'b0;
    end else begin
      place_q <= place_d;
      lin_q   <= lin_d;
      act_q   <= act_d;
    end
  end

  assign start_pos = place_q;
  assign linear    = lin_q;
  assign active    = act_q;

  initial begin
    if (DEF_SLOT >= (1 << SLOT_W)) $error("default slot does not fit SLOT_W");
  end
endmodule

// File: rtl/pcm_rx_poscnt.sv
module pcm_rx_poscnt #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_strobe,
  input  logic             fs_s,
  output logic             frame_start,
  output logic [CNT_W-1:0] pos_now
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [CNT_W-1:0] pos_q, pos_d;
  logic             fs_prev_q, fs_prev_d;

  always_comb begin
    frame_start = bit_strobe & fs_s & ~fs_prev_q;
    if (frame_start)        pos_now = '0;
    else if (pos_q == CMAX) pos_now = CMAX;
    else                    pos_now = pos_q + 1'b1;
    pos_d     = pos_q;
    fs_prev_d = fs_prev_q;
    if (bit_strobe) begin
      pos_d     = pos_now;
      fs_prev_d = fs_s;
    end
  end

  // The position parks at CMAX (outside any start position) until the first frame sync.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q     <= CMAX;
      fs_prev_q <= 1'b0;
    end else begin
      pos_q     <= pos_d;
      fs_prev_q <= fs_prev_d;
    end
  end

  p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_strobe && fs_s && !fs_prev_q) |=> (pos_q == '0));

  p_level_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_strobe && fs_s && fs_prev_q) |=> (pos_q != '0));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_strobe |=> $stable(pos_q));
endmodule

// File: rtl/pcm_rx_shift.sv
module pcm_rx_shift
  import pcm_rx_pkg::*;
#(
  parameter int CNT_W = 11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bit_strobe,
  input  logic                 din_s,
  input  logic                 frame_start,
  input  logic [CNT_W-1:0]     pos_now,
  input  logic [CNT_W-1:0]     start_pos,
  input  logic                 active,
  input  logic                 linear,
  output logic [WORD_BITS-1:0] sample_data,
  output logic                 sample_valid
);
  localparam int LEN_W = $clog2(WORD_BITS + 1);
  localparam logic [LEN_W-1:0] LEN_NARROW = LEN_W'(SLOT_BITS);
  localparam logic [LEN_W-1:0] LEN_WIDE   = LEN_W'(WORD_BITS);

  logic                   busy_q, busy_d;
  logic [LEN_W-1:0]       cnt_q, cnt_d, cnt_inc, len;
  logic [WORD_BITS-2:0]   sh_q, sh_d;
  fmt_e                   fmt_q, fmt_d;
  logic [WORD_BITS-1:0]   data_q, data_d, shifted;
  logic                   valid_q, valid_d;
  logic                   hit;

  always_comb begin
    hit     = bit_strobe & active & (pos_now == start_pos);
    len     = (fmt_q == FMT_LINEAR) ? LEN_WIDE : LEN_NARROW;
    cnt_inc = cnt_q + 1'b1;
    shifted = {sh_q, din_s};
    busy_d  = busy_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    fmt_d   = fmt_q;
    data_d  = data_q;
    valid_d = 1'b0;
    if (hit) begin
      busy_d = 1'b1;
      cnt_d  = LEN_W'(1);
      sh_d   = {{(WORD_BITS-2){1'b0}}, din_s};
      fmt_d  = linear ? FMT_LINEAR : FMT_COMPANDED;
    end else if (bit_strobe && busy_q) begin
      if (frame_start || !active) begin
        busy_d = 1'b0;
      end else begin
        sh_d  = shifted[WORD_BITS-2:0];
        cnt_d = cnt_inc;
        if (cnt_inc == len) begin
          busy_d  = 1'b0;
          valid_d = 1'b1;
          if (fmt_q == FMT_LINEAR) data_d = shifted;
          else data_d = {{(WORD_BITS-SLOT_BITS){1'b0}}, shifted[SLOT_BITS-1:0]};
        end
      end
    end else if (!active) begin
      busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      sh_q    <= '0;
      fmt_q   <= FMT_COMPANDED;
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      fmt_q   <= fmt_d;
      data_q  <= data_d;
      valid_q <= valid_d;
    end
  end

  assign sample_data  = data_q;
  assign sample_valid = valid_q;

  p_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |=> !sample_valid);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_valid |-> $stable(sample_data));

  p_narrow_upper_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_valid && fmt_q == FMT_COMPANDED) |-> (sample_data[WORD_BITS-1:SLOT_BITS] == '0));

  p_count_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q != '0 && cnt_q < len));

  p_standby_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !sample_valid);
endmodule

// File: rtl/pcm_rx_slot_extract.sv
module pcm_rx_slot_extract
  import pcm_rx_pkg::*;
#(
  parameter int CHAN_IDX    = 1,
  parameter int SLOT_W      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bclk_in,
  input  logic                 fs_in,
  input  logic                 din_in,
  input  logic                 cfg_wr_place,
  input  logic [SLOT_W-1:0]    cfg_slot,
  input  logic [2:0]           cfg_bitoff,
  input  logic                 cfg_wr_mode,
  input  logic                 cfg_linear,
  input  logic                 cfg_active,
  output logic [WORD_BITS-1:0] sample_data,
  output logic                 sample_valid
);
  localparam int POS_W = SLOT_W + 3;
  localparam int CNT_W = POS_W + 1;

  // Reset: asserted asynchronously, released through two flops.
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic             bit_strobe, fs_s, din_s, frame_start;
  logic [POS_W-1:0] start_pos;
  logic [CNT_W-1:0] pos_now;
  logic             linear, active;

  pcm_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_sync_q),
    .bclk_raw(bclk_in), .fs_raw(fs_in), .din_raw(din_in),
    .bit_strobe(bit_strobe), .fs_s(fs_s), .din_s(din_s)
  );

  pcm_rx_cfg #(.CHAN_IDX(CHAN_IDX), .SLOT_W(SLOT_W)) u_cfg (
    .clk(clk), .rst_n(rst_sync_q),
    .wr_place(cfg_wr_place), .slot_in(cfg_slot), .bitoff_in(cfg_bitoff),
    .wr_mode(cfg_wr_mode), .linear_in(cfg_linear), .active_in(cfg_active),
    .start_pos(start_pos), .linear(linear), .active(active)
  );

  pcm_rx_poscnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_sync_q),
    .bit_strobe(bit_strobe), .fs_s(fs_s),
    .frame_start(frame_start), .pos_now(pos_now)
  );

  pcm_rx_shift #(.CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst_n(rst_sync_q),
    .bit_strobe(bit_strobe), .din_s(din_s), .frame_start(frame_start),
    .pos_now(pos_now), .start_pos({1'b0, start_pos}),
    .active(active), .linear(linear),
    .sample_data(sample_data), .sample_valid(sample_valid)
  );

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $rose(rst_sync_q) |-> (!sample_valid && sample_data == '0));
endmodule

// File: tb/pcm_rx_slot_extract_test.sv
module pcm_rx_slot_extract_test;
  localparam int FMAX = 512;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bclk_in, fs_in, din_in;
  logic        cfg_wr_place, cfg_wr_mode, cfg_linear, cfg_active;
  logic [6:0]  cfg_slot;
  logic [2:0]  cfg_bitoff;
  logic [15:0] sample_data;
  logic        sample_valid;

  int total = 0;
  int bad   = 0;
  int vcount = 0;
  int wide_err = 0;
  logic [15:0] last_data = '0;
  logic        prev_valid = 1'b0;
  logic        fsv [FMAX];
  logic        dv  [FMAX];

  always #4 clk = ~clk;

  pcm_rx_slot_extract uut (
    .clk(clk), .rst_n(rst_n), .bclk_in(bclk_in), .fs_in(fs_in), .din_in(din_in),
    .cfg_wr_place(cfg_wr_place), .cfg_slot(cfg_slot), .cfg_bitoff(cfg_bitoff),
    .cfg_wr_mode(cfg_wr_mode), .cfg_linear(cfg_linear), .cfg_active(cfg_active),
    .sample_data(sample_data), .sample_valid(sample_valid)
  );

  // Output monitor: samples away from the active edge.
  always @(negedge clk) begin
    if (sample_valid) begin
      vcount++;
      last_data <= sample_data;
    end
    if (sample_valid && prev_valid) wide_err++;
    prev_valid <= sample_valid;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic clear_frame();
    for (int i = 0; i < FMAX; i++) begin
      fsv[i] = 1'b0;
      dv[i]  = logic'(((i >> 1) ^ (i >> 3)) & 1);
    end
    fsv[0] = 1'b1;
  endtask

  task automatic put_bits(input int pos, input int len, input logic [15:0] val);
    for (int i = 0; i < len; i++) dv[pos+i] = val[len-1-i];
  endtask

  function automatic logic [15:0] extract(input int pos, input int len);
    logic [15:0] r = '0;
    for (int i = 0; i < len; i++) r = {r[14:0], dv[pos+i]};
    return r;
  endfunction

  task automatic drive(input int nbits);
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk);
      bclk_in = 1'b1; fs_in = fsv[i]; din_in = dv[i];
      repeat (4) @(negedge clk);
      bclk_in = 1'b0;
      repeat (3) @(negedge clk);
    end
    fs_in = 1'b0;
    repeat (16) @(negedge clk);
  endtask

  task automatic set_place(input int slot, input int off);
    @(negedge clk);
    cfg_wr_place = 1'b1; cfg_slot = 7'(slot); cfg_bitoff = 3'(off);
    @(negedge clk);
    cfg_wr_place = 1'b0;
  endtask

  task automatic set_mode(input bit lin, input bit act);
    @(negedge clk);
    cfg_wr_mode = 1'b1; cfg_linear = lin; cfg_active = act;
    @(negedge clk);
    cfg_wr_mode = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(sample_valid == 1'b0, "R1 valid after reset", 32'(sample_valid), 0);
    check(sample_data == 16'h0, "R1 data after reset", 32'(sample_data), 0);
  endtask

  task automatic t_no_fs();
    int c0;
    set_mode(1'b0, 1'b1);
    clear_frame();
    fsv[0] = 1'b0;
    c0 = vcount;
    drive(200);
    check(vcount == c0, "R10 no sample before first frame sync", 32'(vcount - c0), 0);
  endtask

  task automatic t_defaults();
    int c0;
    clear_frame();
    put_bits(128, 8, 16'h00A5);
    c0 = vcount;
    drive(160);
    check(vcount == c0 + 1, "R1 one sample at default slot", 32'(vcount - c0), 1);
    check(last_data == extract(128, 8), "R2 R4 default slot data", 32'(last_data), 32'(extract(128, 8)));
  endtask

  task automatic t_bit_offset();
    int c0;
    set_place(3, 5);
    clear_frame();
    put_bits(29, 8, 16'h003C);
    c0 = vcount;
    drive(48);
    check(vcount == c0 + 1, "R2 offset sample count", 32'(vcount - c0), 1);
    check(last_data == 16'h003C, "R2 R3 slot 3 offset 5", 32'(last_data), 32'h3C);
    set_place(0, 0);
    clear_frame();
    put_bits(0, 8, 16'h0096);
    drive(16);
    check(last_data == 16'h0096, "R2 sample starts at frame sync bit", 32'(last_data), 32'h96);
    check(wide_err == 0, "R6 valid pulse width", 32'(wide_err), 0);
  endtask

  task automatic t_linear();
    int c0;
    set_mode(1'b1, 1'b1);
    set_place(10, 0);
    clear_frame();
    put_bits(80, 16, 16'hBEEF);
    c0 = vcount;
    drive(100);
    check(vcount == c0 + 1, "R5 linear sample count", 32'(vcount - c0), 1);
    check(last_data == 16'hBEEF, "R5 linear two-slot data", 32'(last_data), 32'hBEEF);
    set_place(20, 7);
    clear_frame();
    put_bits(167, 16, 16'h1234);
    drive(190);
    check(last_data == 16'h1234, "R5 linear with bit offset 7", 32'(last_data), 32'h1234);
  endtask

  task automatic t_standby();
    int c0;
    logic [15:0] held;
    set_mode(1'b0, 1'b0);
    set_place(2, 0);
    clear_frame();
    put_bits(16, 8, 16'h0077);
    c0 = vcount;
    held = sample_data;
    drive(32);
    check(vcount == c0, "R7 no sample while inactive", 32'(vcount - c0), 0);
    check(sample_data == held, "R7 data unchanged while inactive", 32'(sample_data), 32'(held));
  endtask

  task automatic t_deact_mid();
    int c0;
    set_place(5, 0);
    set_mode(1'b0, 1'b1);
    clear_frame();
    put_bits(40, 8, 16'h00E1);
    c0 = vcount;
    fork
      drive(56);
      begin
        repeat (44 * 8 + 6) @(negedge clk);
        set_mode(1'b0, 1'b0);
      end
    join
    check(vcount == c0, "R7 deactivate mid-capture abandons", 32'(vcount - c0), 0);
    set_mode(1'b0, 1'b1);
    clear_frame();
    put_bits(40, 8, 16'h005A);
    drive(56);
    check(last_data == 16'h005A, "R7 fresh capture after reactivation", 32'(last_data), 32'h5A);
  endtask

  task automatic t_fs_restart();
    int c0;
    set_place(1, 0);
    clear_frame();
    put_bits(8, 8, 16'h00FF);
    fsv[12] = 1'b1;
    put_bits(20, 8, 16'h0081);
    c0 = vcount;
    drive(40);
    check(vcount == c0 + 1, "R8 frame sync mid-capture one sample", 32'(vcount - c0), 1);
    check(last_data == extract(20, 8), "R8 sample from restarted frame", 32'(last_data), 32'(extract(20, 8)));
  endtask

  task automatic t_fs_wide();
    int c0;
    set_place(0, 2);
    clear_frame();
    for (int i = 0; i < 5; i++) fsv[i] = 1'b1;
    put_bits(2, 8, 16'h00C3);
    c0 = vcount;
    drive(20);
    check(vcount == c0 + 1, "R9 held frame sync sample count", 32'(vcount - c0), 1);
    check(last_data == 16'h00C3, "R9 held frame sync data", 32'(last_data), 32'hC3);
    check(wide_err == 0, "R6 valid pulse width final", 32'(wide_err), 0);
  endtask

  initial begin
    #(200000 * 8);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    bclk_in = 1'b0; fs_in = 1'b0; din_in = 1'b0;
    cfg_wr_place = 1'b0; cfg_wr_mode = 1'b0;
    cfg_linear = 1'b0; cfg_active = 1'b0;
    cfg_slot = '0; cfg_bitoff = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_no_fs();
    t_defaults();
    t_bit_offset();
    t_linear();
    t_standby();
    t_deact_mid();
    t_fs_restart();
    t_fs_wide();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule